// File: doc/BRIEF.md
# GPIO Pin Interrupt Status Logic

This block detects interrupt conditions on an eight-pin general-purpose input port and reports them through a small 32-bit register interface. Each pin passes through a two-flop synchroniser. It is then tested against its own configuration: level sense (active high or active low) or edge sense (rising, falling, or both edges). The result is held in a raw status bit per pin.

The status bit behaves differently in the two modes. A level-sensed pin's bit follows the input condition and drops by itself once the input leaves its active level. An edge-sensed pin's bit stays set until software writes a one to the clear register at that pin's bit position. A per-pin mask selects which status bits are forwarded. The masked status can be read back. A single registered request line, the OR of all masked bits, goes to the interrupt controller.

Register words (byte offsets on `bus_addr`; only bit n of the low byte relates to pin n): 0x404 level-select (1 = level sense, 0 = edge sense), 0x408 both-edges, 0x40C polarity (1 = rising/high, 0 = falling/low), 0x410 mask, 0x414 raw status (read-only), 0x418 masked status (read-only), 0x41C clear (write-only, reads zero). All other offsets read zero.

Top module: `gpio_irq_stat`

## Requirements
- R1: After reset every register word reads 0x00000000 and `irq` is 0; all pins start as falling-edge sensed and masked off.
- R2: The raw status word is at offset 0x414, holds pin n's status in bit n of bits 7:0, and bits 31:8 of every read word are zero.
- R3: A level-sensed pin's raw bit is 1 exactly while its synchronised input equals the active level (high when polarity is 1, low when 0). It reflects a pin change on the third rising clock edge after the change and not earlier.
- R4: An edge-sensed pin with both-edges 0 sets its raw bit on a rising input transition when polarity is 1 and on a falling one when polarity is 0. The bit stays set after the input returns.
- R5: An edge-sensed pin with both-edges 1 sets its raw bit on either transition, whatever the polarity.
- R6: Writing the clear word clears the raw bit of every edge-sensed pin whose data bit is 1; pins whose data bit is 0 keep their status.
- R7: Writing the clear word has no effect on level-sensed pins.
- R8: If an edge is detected in the same cycle that a clear write to that pin takes effect, the raw bit stays 1.
- R9: The masked status word at 0x418 reads raw status AND mask in bits 7:0.
- R10: `irq` is 1 one clock after any masked status bit is 1, and 0 one clock after none is.
- R11: Writes to the raw and masked status words change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 8 | Asynchronous pin inputs |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register word |
| bus_wdata | input | 8 | Write data (reserved upper bits have no storage) |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq | output | 1 | Combined registered interrupt request |

## Verification
The bench sweeps every pin through all eight sense/polarity/both-edge combinations. It checks the raw word after a rise, after a fall, after a zero clear and after a one clear. A design that mixed up the modes would either keep a level bit sticky or let an edge bit drop by itself. A design that honoured clears on level pins would lose a still-active level. The race between an arriving edge and a clear write is hit on the exact cycle, so a design that gives the clear priority reads back zero. A sweep over all 256 mask values, with a shifting raw pattern, checks the masked word and the one-cycle lag of `irq` on both sides. The synchroniser latency is probed one edge early as well as on time.

// File: rtl/gis_pkg.sv
package gis_pkg;

    localparam int GIS_AW = 12;

    localparam logic [GIS_AW-1:0] OFS_LEVEL = 12'h404;
    localparam logic [GIS_AW-1:0] OFS_BOTH  = 12'h408;
    localparam logic [GIS_AW-1:0] OFS_POL   = 12'h40C;
    localparam logic [GIS_AW-1:0] OFS_MASK  = 12'h410;
    localparam logic [GIS_AW-1:0] OFS_RAW   = 12'h414;
    localparam logic [GIS_AW-1:0] OFS_MSK   = 12'h418;
    localparam logic [GIS_AW-1:0] OFS_CLR   = 12'h41C;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_LEVEL,
        REG_BOTH,
        REG_POL,
        REG_MASK,
        REG_RAW,
        REG_MSK,
        REG_CLR
    } gis_reg_e;

    // Per-pin sense configuration
    typedef struct packed {
        logic level;   // 1: level sense, 0: edge sense
        logic both;    // edge sense only: trigger on either edge
        logic high;    // 1: rising / high active, 0: falling / low active
    } gis_cfg_t;

    function automatic gis_reg_e gis_decode(input logic [GIS_AW-1:0] a);
        gis_reg_e r;
        case (a)
            OFS_LEVEL: r = REG_LEVEL;
            OFS_BOTH:  r = REG_BOTH;
            OFS_POL:   r = REG_POL;
            OFS_MASK:  r = REG_MASK;
            OFS_RAW:   r = REG_RAW;
            OFS_MSK:   r = REG_MSK;
            OFS_CLR:   r = REG_CLR;
            default:   r = REG_NONE;
        endcase
        return r;
    endfunction

    // Interrupt condition of one pin from its current and previous sample
    function automatic logic gis_hit(input gis_cfg_t c, input logic cur, input logic old);
        logic rise;
        logic fall;
        rise = cur & ~old;
        fall = ~cur & old;
        if (c.level)
            return c.high ? cur : ~cur;
        else if (c.both)
            return rise | fall;
        else
            return c.high ? rise : fall;
    endfunction

endpackage

// File: rtl/gis_sync.sv
module gis_sync #(
    parameter int NPIN   = 8,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] pin_i,
    output logic [NPIN-1:0] cur_o,
    output logic [NPIN-1:0] old_o
);

    // STAGES synchroniser flops plus one history flop for edge finding
    logic [NPIN-1:0] pipe_q [STAGES+1];

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q[0] <= '0;
        end else begin
            pipe_q[0] <= pin_i;
        end
    end

    for (genvar k = 1; k <= STAGES; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                pipe_q[k] <= '0;
            end else begin
                pipe_q[k] <= pipe_q[k-1];
            end
        end
    end

    assign cur_o = pipe_q[STAGES-1];
    assign old_o = pipe_q[STAGES];

endmodule

// File: rtl/gis_detect.sv
module gis_detect
    import gis_pkg::*;
#(
    parameter int NPIN = 8
) (
    input  gis_cfg_t [NPIN-1:0] cfg_i,
    input  logic     [NPIN-1:0] cur_i,
    input  logic     [NPIN-1:0] old_i,
    output logic     [NPIN-1:0] hit_o
);

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        assign hit_o[g] = gis_hit(cfg_i[g], cur_i[g], old_i[g]);
    end

endmodule

// File: rtl/gis_status.sv
module gis_status
    import gis_pkg::*;
#(
    parameter int NPIN = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  gis_cfg_t [NPIN-1:0] cfg_i,
    input  logic     [NPIN-1:0] hit_i,
    input  logic     [NPIN-1:0] clr_i,
    output logic     [NPIN-1:0] raw_o
);

    for (genvar g = 0; g < NPIN; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                raw_o[g] <= 1'b0;
            end else if (cfg_i[g].level) begin
                // transparent: follows the condition, clears itself
                raw_o[g] <= hit_i[g];
            end else begin
                // sticky: a new edge beats a simultaneous clear
                raw_o[g] <= hit_i[g] | (raw_o[g] & ~clr_i[g]);
            end
        end
    end

endmodule

// File: rtl/gis_regs.sv
module gis_regs
    import gis_pkg::*;
#(
    parameter int NPIN = 8,
    parameter int DW   = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [GIS_AW-1:0]   bus_addr,
    input  logic [NPIN-1:0]     bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    input  logic [NPIN-1:0]     raw_i,
    output gis_cfg_t [NPIN-1:0] cfg_o,
    output logic [NPIN-1:0]     mask_o,
    output logic [NPIN-1:0]     clr_o,
    output logic                irq_o
);

    localparam int PAD = DW - NPIN;

    gis_reg_e        sel;
    logic            wr_en;
    logic [NPIN-1:0] level_q;
    logic [NPIN-1:0] both_q;
    logic [NPIN-1:0] high_q;
    logic [NPIN-1:0] mask_q;
    logic [NPIN-1:0] masked;
    logic [NPIN-1:0] rd_vec;

    assign sel   = bus_sel ? gis_decode(bus_addr) : REG_NONE;
    assign wr_en = bus_sel & bus_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
            both_q  <= '0;
            high_q  <= '0;
            mask_q  <= '0;
        end else if (wr_en) begin
            case (sel)
                REG_LEVEL: level_q <= bus_wdata;
                REG_BOTH:  both_q  <= bus_wdata;
                REG_POL:   high_q  <= bus_wdata;
                REG_MASK:  mask_q  <= bus_wdata;
                default:   ;
            endcase
        end
    end

    // clear pulse, only for edge-sensed pins
    assign clr_o = (wr_en && sel == REG_CLR) ? (bus_wdata & ~level_q) : '0;

    for (genvar g = 0; g < NPIN; g++) begin : g_cfg
        assign cfg_o[g].level = level_q[g];
        assign cfg_o[g].both  = both_q[g];
        assign cfg_o[g].high  = high_q[g];
    end

    assign mask_o = mask_q;
    assign masked = raw_i & mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= |masked;
        end
    end

    always_comb begin
        case (sel)
            REG_LEVEL: rd_vec = level_q;
            REG_BOTH:  rd_vec = both_q;
            REG_POL:   rd_vec = high_q;
            REG_MASK:  rd_vec = mask_q;
            REG_RAW:   rd_vec = raw_i;
            REG_MSK:   rd_vec = masked;
            default:   rd_vec = '0;
        endcase
    end

    assign bus_rdata = {{PAD{1'b0}}, rd_vec};

endmodule

// File: rtl/gpio_irq_stat.sv
module gpio_irq_stat
    import gis_pkg::*;
#(
    parameter int NPIN        = 8,
    parameter int DW          = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPIN-1:0]   pin_in,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [GIS_AW-1:0] bus_addr,
    input  logic [NPIN-1:0]   bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq
);

    logic [NPIN-1:0]     cur;
    logic [NPIN-1:0]     old;
    logic [NPIN-1:0]     hit;
    logic [NPIN-1:0]     raw_q;
    logic [NPIN-1:0]     mask_q;
    logic [NPIN-1:0]     clr;
    logic [NPIN-1:0]     level_v;
    gis_cfg_t [NPIN-1:0] cfg;

    gis_sync #(.NPIN(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .pin_i (pin_in),
        .cur_o (cur),
        .old_o (old)
    );

    gis_detect #(.NPIN(NPIN)) u_det (
        .cfg_i (cfg),
        .cur_i (cur),
        .old_i (old),
        .hit_o (hit)
    );

    gis_status #(.NPIN(NPIN)) u_stat (
        .clk   (clk),
        .rst   (rst),
        .cfg_i (cfg),
        .hit_i (hit),
        .clr_i (clr),
        .raw_o (raw_q)
    );

    gis_regs #(.NPIN(NPIN), .DW(DW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .raw_i     (raw_q),
        .cfg_o     (cfg),
        .mask_o    (mask_q),
        .clr_o     (clr),
        .irq_o     (irq)
    );

    for (genvar g = 0; g < NPIN; g++) begin : g_lvl
        assign level_v[g] = cfg[g].level;
    end

endmodule

// File: rtl/gis_chk.sv
module gis_chk
    import gis_pkg::*;
#(
    parameter int NPIN = 8,
    parameter int DW   = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic [GIS_AW-1:0] bus_addr,
    input logic [DW-1:0]     bus_rdata,
    input logic              irq,
    input logic [NPIN-1:0]   raw_q,
    input logic [NPIN-1:0]   mask_q,
    input logic [NPIN-1:0]   level_v,
    input logic [NPIN-1:0]   hit,
    input logic [NPIN-1:0]   clr
);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (raw_q == '0 && !irq));

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_addr == OFS_RAW) |-> (bus_rdata[DW-1:NPIN] == '0));

    // R3
    level_track_chk: assert property (@(posedge clk) disable iff (rst)
        ((raw_q ^ $past(hit)) & $past(level_v)) == '0);

    // R6
    edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(raw_q) & ~$past(level_v) & ~$past(clr) & ~raw_q) == '0);

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(hit) & ~$past(level_v) & ~raw_q) == '0);

    // R9
    masked_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_addr == OFS_MSK) |-> (bus_rdata[NPIN-1:0] == (raw_q & mask_q)));

    // R10
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (|(raw_q & mask_q)) |=> irq);

    // R10
    irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !(|(raw_q & mask_q)) |=> !irq);

endmodule

bind gpio_irq_stat gis_chk #(.NPIN(NPIN), .DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .raw_q     (raw_q),
    .mask_q    (mask_q),
    .level_v   (level_v),
    .hit       (hit),
    .clr       (clr)
);

// File: tb/sim_gpio_irq_stat.sv
`timescale 1ns/100ps
module sim_gpio_irq_stat;

    localparam logic [11:0] A_LEVEL = 12'h404;
    localparam logic [11:0] A_BOTH  = 12'h408;
    localparam logic [11:0] A_POL   = 12'h40C;
    localparam logic [11:0] A_MASK  = 12'h410;
    localparam logic [11:0] A_RAW   = 12'h414;
    localparam logic [11:0] A_MSK   = 12'h418;
    localparam logic [11:0] A_CLR   = 12'h41C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  pin_in = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    gpio_irq_stat u0 (
        .clk       (clk),
        .rst       (rst),
        .pin_in    (pin_in),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [7:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, d, {24'h0, exp});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements): got hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [7:0]  bit_p;
        logic [7:0]  exp_r;
        logic        lvl, both, high, after_rise;
        logic [7:0]  v, m, m_prev;
        string       tag;

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state of every word and of irq
        rd_chk("R1 level", A_LEVEL, 8'h00);
        rd_chk("R1 both",  A_BOTH,  8'h00);
        rd_chk("R1 pol",   A_POL,   8'h00);
        rd_chk("R1 mask",  A_MASK,  8'h00);
        rd_chk("R1 raw",   A_RAW,   8'h00);
        rd_chk("R1 masked", A_MSK,  8'h00);
        rd_chk("R1 clear", A_CLR,   8'h00);
        check("R1 irq", {31'h0, irq}, 32'h0);

        // Sweep: every pin through every sense configuration
        for (int p = 0; p < 8; p++) begin
            for (int c = 0; c < 8; c++) begin
                bit_p = 8'(1 << p);
                lvl  = c[2];
                both = c[1];
                high = c[0];
                tag  = lvl ? "R3" : (both ? "R5" : "R4");
                @(negedge clk);
                pin_in = '0;
                wr(A_LEVEL, lvl  ? bit_p : 8'h00);
                wr(A_BOTH,  both ? bit_p : 8'h00);
                wr(A_POL,   high ? bit_p : 8'h00);
                settle();
                wr(A_CLR, 8'hFF);
                exp_r = (lvl && !high) ? bit_p : 8'h00;
                rd_chk({tag, " idle"}, A_RAW, exp_r);

                @(negedge clk);
                pin_in = bit_p;
                settle();
                after_rise = lvl ? high : (both | high);
                exp_r = after_rise ? bit_p : 8'h00;
                rd_chk({tag, " R2 after rise"}, A_RAW, exp_r);

                @(negedge clk);
                pin_in = '0;
                settle();
                if (lvl) exp_r = high ? 8'h00 : bit_p;
                else     exp_r = (after_rise | both | !high) ? bit_p : 8'h00;
                rd_chk({tag, " after fall"}, A_RAW, exp_r);

                wr(A_CLR, 8'h00);
                rd_chk("R6 zero clear keeps status", A_RAW, exp_r);

                wr(A_CLR, bit_p);
                if (lvl) begin
                    exp_r = high ? 8'h00 : bit_p;
                    rd_chk("R7 clear ignored on level pin", A_RAW, exp_r);
                end else begin
                    rd_chk("R6 one clear", A_RAW, 8'h00);
                end
            end
        end

        // R3: synchroniser latency, level-high on pin 0
        wr(A_LEVEL, 8'h01);
        wr(A_BOTH,  8'h00);
        wr(A_POL,   8'h01);
        settle();
        @(negedge clk);
        pin_in = 8'h01;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rd_chk("R3 not before third edge", A_RAW, 8'h00);
        @(posedge clk);
        @(negedge clk);
        rd_chk("R3 on third edge", A_RAW, 8'h01);
        @(negedge clk);
        pin_in = 8'h00;
        settle();
        rd_chk("R3 self clear", A_RAW, 8'h00);

        // R8: edge arrives on the cycle a clear takes effect
        wr(A_LEVEL, 8'h00);
        wr(A_POL,   8'hFF);
        settle();
        wr(A_CLR, 8'hFF);
        @(negedge clk);
        pin_in = 8'h01;
        settle();
        @(negedge clk);
        pin_in = 8'h00;
        settle();
        rd_chk("R8 setup sticky", A_RAW, 8'h01);
        @(negedge clk);
        pin_in = 8'h01;
        @(posedge clk);
        @(posedge clk);
        wr(A_CLR, 8'h01);
        rd_chk("R8 set wins over clear", A_RAW, 8'h01);
        wr(A_CLR, 8'h01);
        rd_chk("R8 later clear works", A_RAW, 8'h00);

        // R11: status words ignore writes (edge mode, empty status)
        wr(A_RAW, 8'hFF);
        wr(A_MSK, 8'hFF);
        rd_chk("R11 raw write ignored", A_RAW, 8'h00);
        rd_chk("R11 mask untouched", A_MASK, 8'h00);

        // R9 / R10: all mask values against a moving raw pattern
        wr(A_LEVEL, 8'hFF);
        wr(A_POL,   8'hFF);
        m_prev = 8'h00;
        for (int k = 0; k < 256; k++) begin
            m = 8'(k);
            v = 8'((k * 37 + 11) & 255);
            @(negedge clk);
            pin_in = v;
            settle();
            wr(A_MASK, m);
            check("R10 irq lags mask by one clock", {31'h0, irq}, {31'h0, |(v & m_prev)});
            rd_chk("R3 R2 raw pattern", A_RAW, v);
            rd_chk("R9 masked status", A_MSK, v & m);
            @(posedge clk);
            @(negedge clk);
            check("R10 irq", {31'h0, irq}, {31'h0, |(v & m)});
            m_prev = m;
        end

        // R11: level-mode status words ignore writes
        wr(A_RAW, 8'h00);
        wr(A_MSK, 8'h00);
        rd_chk("R11 raw after write", A_RAW, v);
        rd_chk("R11 masked after write", A_MSK, v & m);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule